// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the pre-divider and feedback divider settings for a clock synthesiser. Software or a sequencer presents a reference clock rate and a wanted high-speed rate, both in hertz, and pulses `start`. The engine halves the reference to get the comparison reference. It caps the wanted rate at a ceiling. It then walks every pre-divider that keeps the phase-detector frequency inside an allowed band.

For each pre-divider the engine derives the largest feedback divider that does not overshoot, and rejects feedback values the PLL cannot take. For the values it keeps, it computes the rate those settings really produce. It keeps the pair with the smallest error and stops early on an exact hit. A single shared restoring divider that yields one quotient bit per clock does all the arithmetic, so a search takes a few hundred cycles per pre-divider.

When the walk ends, `done` pulses for one cycle. `valid` then reports whether any pair was found, and the divider outputs hold the chosen pair.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `prediv_o` and `fbdiv_o` read 1, `rate_o` reads 0, and `valid_o` and `done_o` read 0.
- R2: `ref_hz_i` and `target_hz_i` are captured in the cycle `start_i` is seen while idle. A `start_i` pulse during a running search is ignored and does not change that search's result.
- R3: The comparison reference is floor(`ref_hz_i`/2). A target above 1,000,000,000 is treated as exactly 1,000,000,000.
- R4: Pre-dividers are tried in ascending order from ceil(fref/40,000,000) to floor(fref/5,000,000). The first value tried is never below 1. An empty window yields no candidate.
- R5: For pre-divider p, the feedback candidate is floor(target·p/fref). It is rejected when it is below 12, above 511 or equal to 15.
- R6: An accepted candidate achieves floor(fb·fref/p), which never exceeds the target. Its error is the absolute difference from the target.
- R7: A candidate replaces the best pair only when its error is strictly smaller, so on equal error the smaller pre-divider stays.
- R8: A zero-error candidate is taken and ends the search at once. For the same window, an exact search finishes in fewer cycles than one that walks the whole window.
- R9: Each accepted start gives exactly one `done_o` pulse of one cycle. The four result outputs change only in the cycle `done_o` is high.
- R10: When a candidate was found, `valid_o`=1 and `prediv_o`, `fbdiv_o` and `rate_o` give the best pair and its achieved rate. Otherwise `valid_o`=0, `rate_o`=0, and `prediv_o` and `fbdiv_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (sampled while idle) |
| ref_hz_i | input | RATE_W | Reference clock rate in Hz |
| target_hz_i | input | RATE_W | Requested high-speed rate in Hz |
| prediv_o | output | PREDIV_W | Chosen pre-divider |
| fbdiv_o | output | FBDIV_W | Chosen feedback divider |
| rate_o | output | RATE_W | Achieved rate of the last search, 0 if none |
| valid_o | output | 1 | Last search found a pair |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 32-bit rates, a 1 GHz ceiling, a 5 to 40 MHz comparison band, and 12 to 511 feedback with 15 excluded. These values let small references such as 20 MHz and 48 MHz produce windows of one to four pre-dividers, where the excluded feedback value, empty windows and equal-error ties can be arranged by hand. A 200 MHz reference moves the window's lower edge above 1, so an exact pair just below the window must be skipped. A 24 MHz or larger reference with a multi-gigahertz request exercises the ceiling.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef logic [63:0] pds_word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LO,
    S_HI,
    S_STEP,
    S_FB,
    S_RATE,
    S_FINISH
  } pds_state_e;

  // True when a feedback value is one the PLL can use.
  function automatic logic pds_fb_allowed(pds_word_t fb, int unsigned lo,
                                          int unsigned hi, int unsigned skip);
    return (fb >= pds_word_t'(lo)) && (fb <= pds_word_t'(hi)) &&
           (fb != pds_word_t'(skip));
  endfunction

  function automatic pds_word_t pds_absdiff(pds_word_t a, pds_word_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/pds_restoring_div.sv
module pds_restoring_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     acc_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [W:0]       trial, diff;
  logic             fits;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    trial = {acc_q, quo_q[W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = !diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go_i) begin
      acc_q  <= '0;
      quo_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      acc_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = acc_q;
  assign done_o = done_q;

  // R6: every finished division leaves a remainder below the divisor
  a_r6_div_remainder: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && den_q != '0) |-> (acc_q < den_q));

endmodule

// File: rtl/pds_judge.sv
module pds_judge
  import pds_pkg::*;
#(
  parameter int unsigned FB_LO   = 12,
  parameter int unsigned FB_HI   = 511,
  parameter int unsigned FB_SKIP = 15
) (
  input  pds_word_t quo_i,
  input  pds_word_t target_i,
  input  pds_word_t best_err_i,
  output logic      fb_ok_o,
  output pds_word_t err_o,
  output logic      exact_o,
  output logic      better_o
);
  // quo_i is read as a feedback candidate or as an achieved rate, by state.
  always_comb begin
    fb_ok_o  = pds_fb_allowed(quo_i, FB_LO, FB_HI, FB_SKIP);
    err_o    = pds_absdiff(target_i, quo_i);
    exact_o  = (err_o == '0);
    better_o = (err_o < best_err_i);
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pds_pkg::*;
#(
  parameter int          RATE_W     = 32,  // at most 32: products fit 64 bits
  parameter int          PREDIV_W   = 8,
  parameter int          FBDIV_W    = 9,
  parameter int unsigned RATE_CAP   = 1_000_000_000,
  parameter int unsigned CMP_MAX_HZ = 40_000_000,
  parameter int unsigned CMP_MIN_HZ = 5_000_000,
  parameter int unsigned FB_LO      = 12,
  parameter int unsigned FB_HI      = 511,
  parameter int unsigned FB_SKIP    = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [RATE_W-1:0]   ref_hz_i,
  input  logic [RATE_W-1:0]   target_hz_i,
  output logic [PREDIV_W-1:0] prediv_o,
  output logic [FBDIV_W-1:0]  fbdiv_o,
  output logic [RATE_W-1:0]   rate_o,
  output logic                valid_o,
  output logic                done_o
);
  localparam int PROD_W = 2 * RATE_W;
  localparam logic [RATE_W-1:0] CAP_V = RATE_W'(RATE_CAP);
  localparam logic [RATE_W-1:0] ZERO_HI = '0;

  pds_state_e        st_q;
  logic [RATE_W-1:0] fref_q, tgt_q, lo_q, hi_q, p_q;
  logic [PROD_W-1:0] fb_q;
  logic [RATE_W-1:0] best_p_q, best_rate_q;
  logic [PROD_W-1:0] best_fb_q, best_err_q;
  logic              found_q, go_q;

  logic [PROD_W-1:0] div_num, div_den, div_quo, div_rem;
  logic              div_done;
  pds_word_t         j_err;
  logic              j_fb_ok, j_exact, j_better;

  // named events for the checks
  logic fb_ev, take_ev, exact_ev, finish_ev;

  // operand selection for the single shared divider
  always_comb begin
    div_num = '0;
    div_den = {ZERO_HI, RATE_W'(1)};
    unique case (st_q)
      S_LO: begin
        div_num = {ZERO_HI, fref_q} + PROD_W'(CMP_MAX_HZ - 1);
        div_den = {ZERO_HI, RATE_W'(CMP_MAX_HZ)};
      end
      S_HI: begin
        div_num = {ZERO_HI, fref_q};
        div_den = {ZERO_HI, RATE_W'(CMP_MIN_HZ)};
      end
      S_FB: begin
        div_num = {ZERO_HI, tgt_q} * {ZERO_HI, p_q};
        div_den = {ZERO_HI, fref_q};
      end
      S_RATE: begin
        div_num = fb_q * {ZERO_HI, fref_q};
        div_den = {ZERO_HI, p_q};
      end
      default: ;
    endcase
  end

  pds_restoring_div #(.W(PROD_W)) i_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go_q),
    .num_i  (div_num),
    .den_i  (div_den),
    .quo_o  (div_quo),
    .rem_o  (div_rem),
    .done_o (div_done)
  );

  pds_judge #(.FB_LO(FB_LO), .FB_HI(FB_HI), .FB_SKIP(FB_SKIP)) i_judge (
    .quo_i      (div_quo),
    .target_i   ({ZERO_HI, tgt_q}),
    .best_err_i (best_err_q),
    .fb_ok_o    (j_fb_ok),
    .err_o      (j_err),
    .exact_o    (j_exact),
    .better_o   (j_better)
  );

  assign fb_ev     = (st_q == S_FB) && div_done;
  assign take_ev   = (st_q == S_RATE) && div_done && (j_exact || j_better);
  assign exact_ev  = (st_q == S_RATE) && div_done && j_exact;
  assign finish_ev = (st_q == S_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      fref_q      <= '0;
      tgt_q       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      p_q         <= '0;
      fb_q        <= '0;
      best_p_q    <= RATE_W'(1);
      best_fb_q   <= PROD_W'(1);
      best_rate_q <= '0;
      best_err_q  <= '1;
      found_q     <= 1'b0;
      go_q        <= 1'b0;
      prediv_o    <= PREDIV_W'(1);
      fbdiv_o     <= FBDIV_W'(1);
      rate_o      <= '0;
      valid_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          fref_q      <= ref_hz_i >> 1;
          tgt_q       <= (target_hz_i > CAP_V) ? CAP_V : target_hz_i;
          best_p_q    <= RATE_W'(1);
          best_fb_q   <= PROD_W'(1);
          best_rate_q <= '0;
          best_err_q  <= '1;
          found_q     <= 1'b0;
          st_q        <= S_LO;
          go_q        <= 1'b1;
        end
        S_LO: if (div_done) begin
          lo_q <= div_quo[RATE_W-1:0];
          st_q <= S_HI;
          go_q <= 1'b1;
        end
        S_HI: if (div_done) begin
          hi_q <= div_quo[RATE_W-1:0];
          p_q  <= (lo_q == '0) ? RATE_W'(1) : lo_q;
          st_q <= S_STEP;
        end
        S_STEP: begin
          if (p_q > hi_q) begin
            st_q <= S_FINISH;
          end else begin
            st_q <= S_FB;
            go_q <= 1'b1;
          end
        end
        S_FB: if (div_done) begin
          fb_q <= div_quo;
          if (j_fb_ok) begin
            st_q <= S_RATE;
            go_q <= 1'b1;
          end else begin
            p_q  <= p_q + 1'b1;
            st_q <= S_STEP;
          end
        end
        S_RATE: if (div_done) begin
          if (j_exact || j_better) begin
            best_p_q    <= p_q;
            best_fb_q   <= fb_q;
            best_rate_q <= div_quo[RATE_W-1:0];
            best_err_q  <= j_err;
            found_q     <= 1'b1;
          end
          if (j_exact) begin
            st_q <= S_FINISH;
          end else begin
            p_q  <= p_q + 1'b1;
            st_q <= S_STEP;
          end
        end
        S_FINISH: begin
          done_o  <= 1'b1;
          valid_o <= found_q;
          rate_o  <= found_q ? best_rate_q : '0;
          if (found_q) begin
            prediv_o <= best_p_q[PREDIV_W-1:0];
            fbdiv_o  <= best_fb_q[FBDIV_W-1:0];
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: results move only together with done
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(prediv_o) && $stable(fbdiv_o) && $stable(rate_o) && $stable(valid_o)));

  // R5: a reported feedback divider is always a legal one
  a_r5_fb_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (fbdiv_o >= FBDIV_W'(FB_LO) && fbdiv_o <= FBDIV_W'(FB_HI) &&
                             fbdiv_o != FBDIV_W'(FB_SKIP)));

  // R4: only pre-dividers inside the window are ever taken
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |-> (p_q >= lo_q && p_q <= hi_q && p_q != '0));

  // R6: the achieved rate never overshoots the capped target
  a_r6_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |-> (div_quo <= {ZERO_HI, tgt_q}));

  // R10: a failed search reports a zero rate
  a_r10_no_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (rate_o == '0));

  // R8: an exact hit goes straight to completion
  a_r8_exact_stop: assert property (@(posedge clk) disable iff (!rst_n)
    exact_ev |=> finish_ev);

  // R3: the working target never exceeds the ceiling
  a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (tgt_q <= CAP_V));

  // R5: a rejected feedback candidate never reaches the rate step
  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_ev && !j_fb_ok) |=> (st_q == S_STEP));

endmodule

// File: tb/test_pll_div_search.sv
module test_pll_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ref_hz_i = '0;
  logic [31:0] target_hz_i = '0;
  logic [7:0]  prediv_o;
  logic [8:0]  fbdiv_o;
  logic [31:0] rate_o;
  logic        valid_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // values expected to be held from run to run (R10)
  longint unsigned held_p = 1;
  longint unsigned held_fb = 1;

  always #2.5 clk = ~clk;

  pll_div_search i_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_hz_i(ref_hz_i),
    .target_hz_i(target_hz_i), .prediv_o(prediv_o), .fbdiv_o(fbdiv_o),
    .rate_o(rate_o), .valid_o(valid_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Independent model of the search, straight 64-bit arithmetic.
  task automatic model(input longint unsigned rf, input longint unsigned tg,
                       output bit ok, output longint unsigned bp,
                       output longint unsigned bfb, output longint unsigned br);
    longint unsigned fref, t, lo, hi, fb, r, e, be;
    fref = rf / 2;
    t = (tg > 64'd1000000000) ? 64'd1000000000 : tg;
    lo = (fref + 40000000 - 1) / 40000000;
    hi = fref / 5000000;
    if (lo == 0) lo = 1;
    be = '1; ok = 0; bp = 1; bfb = 1; br = 0;
    for (longint unsigned p = lo; p <= hi; p++) begin
      fb = t * p / fref;
      if (fb == 15 || fb < 12 || fb > 511) continue;
      r = fb * fref / p;
      e = (t > r) ? t - r : r - t;
      if (e < be) begin
        be = e; bp = p; bfb = fb; br = r; ok = 1;
      end
      if (e == 0) break;
    end
  endtask

  // Start a search and wait for done; returns latency in cycles.
  task automatic launch(input longint unsigned rf, input longint unsigned tg,
                        output int lat);
    @(negedge clk);
    ref_hz_i = rf[31:0];
    target_hz_i = tg[31:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(input string tag, input longint unsigned rf,
                          input longint unsigned tg, output int lat);
    bit ok;
    longint unsigned bp, bfb, br;
    model(rf, tg, ok, bp, bfb, br);
    launch(rf, tg, lat);
    chk(done_o == 1'b1, {tag, " done"}, done_o, 1);
    chk(valid_o == ok, {tag, " valid"}, valid_o, ok);
    if (ok) begin held_p = bp; held_fb = bfb; end
    chk(prediv_o == held_p, {tag, " prediv"}, prediv_o, held_p);
    chk(fbdiv_o == held_fb, {tag, " fbdiv"}, fbdiv_o, held_fb);
    chk(rate_o == (ok ? br : 0), {tag, " rate"}, rate_o, ok ? br : 0);
    @(negedge clk);
    // R9: single-cycle pulse
    chk(done_o == 1'b0, {tag, " R9 done drops"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk(prediv_o == 1, "R1 prediv", prediv_o, 1);
    chk(fbdiv_o == 1, "R1 fbdiv", fbdiv_o, 1);
    chk(rate_o == 0, "R1 rate", rate_o, 0);
    chk(valid_o == 0, "R1 valid", valid_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
  endtask

  task automatic t_exact_vs_full;
    int la, lb;
    run_case("R8 exact 48M/240M", 48000000, 240000000, la);
    chk(prediv_o == 2 && fbdiv_o == 20, "R8 pair", {prediv_o, fbdiv_o}, {8'd2, 9'd20});
    // R7: equal error at p=2,3,4 keeps p=2
    run_case("R7 tie 48M/241M", 48000000, 241000000, lb);
    chk(prediv_o == 2, "R7 smaller prediv kept", prediv_o, 2);
    chk(la < lb, "R8 early exit latency", la, lb);
  endtask

  task automatic t_clamp_and_half;
    int l;
    run_case("R3 clamp 48M/1.5G", 48000000, 1500000000, l);
    chk(rate_o == 1000000000, "R3 capped rate", rate_o, 1000000000);
    run_case("R3 odd ref", 48000001, 240000000, l);
    run_case("R6 24M/594M", 24000000, 594000000, l);
  endtask

  task automatic t_fb_rules;
    int l;
    // fb=15 at p=1 must be skipped, p=2 gives fb=30
    run_case("R5 skip fifteen", 20000000, 150000000, l);
    chk(fbdiv_o == 30, "R5 fb30", fbdiv_o, 30);
    // only fb 5 and 10: nothing legal, previous pair kept
    run_case("R10 no candidate", 20000000, 50000000, l);
    chk(prediv_o == 2 && fbdiv_o == 30, "R10 held pair", {prediv_o, fbdiv_o}, {8'd2, 9'd30});
  endtask

  task automatic t_window;
    int l;
    // exact pair at p=2 lies below the window (lo=3); p=3 taken
    run_case("R4 lower edge", 200000000, 600000000, l);
    chk(prediv_o == 3 && fbdiv_o == 18, "R4 lo", {prediv_o, fbdiv_o}, {8'd3, 9'd18});
    // p=3 would be better but lies above the window (hi=2)
    run_case("R4 upper edge", 20000000, 123456789, l);
    chk(prediv_o == 1 && fbdiv_o == 12, "R4 hi", {prediv_o, fbdiv_o}, {8'd1, 9'd12});
    // empty window
    run_case("R4 empty", 4000000, 300000000, l);
  endtask

  task automatic t_busy_start;
    int lat;
    bit ok;
    longint unsigned bp, bfb, br;
    model(48000000, 594000000, ok, bp, bfb, br);
    @(negedge clk);
    ref_hz_i = 48000000; target_hz_i = 594000000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    ref_hz_i = 20000000; target_hz_i = 150000000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40000) begin @(negedge clk); lat++; end
    if (ok) begin held_p = bp; held_fb = bfb; end
    chk(prediv_o == held_p, "R2 prediv unaffected", prediv_o, held_p);
    chk(fbdiv_o == held_fb, "R2 fbdiv unaffected", fbdiv_o, held_fb);
    chk(rate_o == br, "R2 rate unaffected", rate_o, br);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R2 no second done", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact_vs_full();
    t_clamp_and_half();
    t_fb_rules();
    t_window();
    t_busy_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule